// File: doc/BRIEF.md
# MII Transmit Framer with Frame Check Sequence

This block puts one Ethernet frame onto a 4-bit media independent interface. Control logic gives it a byte length and a start pulse. The block then drives a 16-nibble preamble and start delimiter. It fetches the frame bytes as 32-bit words from an external dual-port transmit buffer with one cycle of read latency, and sends them one nibble per transmit clock. It pads short frames with zero bytes and appends the 32-bit frame check sequence, which it builds one nibble at a time. Everything runs in the transmit clock domain, so the same logic serves both 10 and 100 Mb/s line rates.

The duplex mode is chosen per frame. In half-duplex mode the block waits while carrier sense is high. A collision during the frame switches it to a 32-bit jam pattern, after which it stops and reports the collision. In full-duplex mode it ignores both carrier sense and collision. When a frame ends, normally or after a jam, the block gives a one-cycle done pulse.

Top module: `mii_tx_framer`

## Requirements
- R1: After reset, txEn, done, busy and collided are low and txData is 0.
- R2: When start is sampled in idle with no deferral, the next 16 cycles carry txEn high and txData equal to 0x5 fifteen times and then 0xD.
- R3: Frame byte n is taken from buffer word n/4, bits [8*(n%4)+7 : 8*(n%4)]. Its low nibble is sent first, and the bytes follow directly after the start delimiter in ascending order.
- R4: Each buffer word is requested with memRdEn one cycle before its data is captured. The requested addresses run 0, 1, 2 ... up to ceil(frameLen/4)-1, each exactly once, and no address at or beyond that limit is requested.
- R5: When frameLen is below 60, the frame is extended with zero bytes to 60 bytes before the check sequence. A frameLen of 0 sends 60 zero bytes.
- R6: Eight check-sequence nibbles follow the last payload nibble. The remainder uses the reflected CRC-32 polynomial 0xEDB88320, is preset to all ones and runs over the padded payload, least significant bit of each nibble first. Its complement is sent, with nibble i equal to bits [4i+3:4i].
- R7: In the cycle after the last nibble, txEn is low and done is high for exactly one cycle. The cycle after that, busy is low.
- R8: A start pulse while busy is ignored. The frame in progress is unchanged and no further frame follows.
- R9: With halfDuplex high, a start seen while crs is high keeps txEn low until crs is sampled low. The preamble begins the cycle after that. With halfDuplex low, crs has no effect.
- R10: With halfDuplex high, a col sampled high during the preamble, data or check sequence is followed from the next cycle by eight nibbles of 0xA with txEn high. The end cycle of R7 follows, with collided high. With halfDuplex low, col has no effect and collided stays low.
- R11: txEr is always low. The block has no error condition to report during transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a frame when the block is idle |
| frameLen | input | 12 | Frame length in bytes, without check sequence (0 to 2048) |
| halfDuplex | input | 1 | Selects half-duplex behaviour for the next frame |
| crs | input | 1 | Carrier sense from the PHY |
| col | input | 1 | Collision indication from the PHY |
| memRdAddr | output | 9 | Word address to the transmit buffer |
| memRdEn | output | 1 | Read request to the transmit buffer |
| memRdData | input | 32 | Buffer word, valid the cycle after the request |
| txData | output | 4 | Transmit nibble to the PHY |
| txEn | output | 1 | Transmit enable to the PHY |
| txEr | output | 1 | Transmit error to the PHY, held low |
| done | output | 1 | One-cycle pulse at the end of a frame |
| collided | output | 1 | The last frame ended in a jam |
| busy | output | 1 | A frame is pending or in progress |

## Verification
The framer is tried with frame lengths 0, 10, 60, 61, 64 and 100. Each length tests a different thing: padding versus no padding, a partial last word, and the exact word count requested from the buffer. Every nibble is compared against a bytewise CRC model. Half-duplex runs add a carrier held high at start, which moves the preamble later, and collisions in the preamble and in the payload, which truncate the frame at a known cycle. The same carrier and collision inputs in full-duplex mode must leave the frame intact. A start pulse in the middle of a frame must change neither the output nor the buffer addresses.

// File: rtl/mii_txf_pkg.sv
package mii_txf_pkg;

  localparam logic [3:0]  PRE_NIB    = 4'h5;
  localparam logic [3:0]  SFD_NIB    = 4'hD;
  localparam logic [3:0]  JAM_NIB    = 4'hA;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

  typedef enum logic [2:0] {
    SEL_IDLE, SEL_PRE, SEL_SFD, SEL_DATA, SEL_FCS, SEL_JAM
  } nibSel_e;

  // strobes from control to datapath
  typedef struct packed {
    nibSel_e    sel;
    logic       crcInit;
    logic       crcStep;
    logic       crcShift;
    logic       loadWord;
    logic [1:0] lane;
    logic       hiNib;
    logic       padZero;
  } txStrobe_t;

  // reflected CRC-32 update, nibble bit 0 first
  function automatic logic [31:0] crcNibble(input logic [31:0] cIn, input logic [3:0] d);
    logic [31:0] c;
    c = cIn;
    for (int j = 0; j < 4; j++) begin
      if (c[0] ^ d[j]) c = (c >> 1) ^ CRC_POLY_R;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import mii_txf_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int LEN_W     = 12,
  parameter int MIN_BYTES = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              halfDuplex,
  input  logic              crs,
  input  logic              col,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output txStrobe_t         stb,
  output logic              txEn,
  output logic              done,
  output logic              collided,
  output logic              busy
);

  localparam int CNT_W = LEN_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEFER, ST_PRE, ST_DATA, ST_FCS, ST_JAM, ST_END
  } state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] lenQ;
  logic             hdQ;
  logic             colFlag;
  logic             rdPend;

  logic [LEN_W-1:0] padLen;
  logic [CNT_W-1:0] payNibs;
  logic [CNT_W-1:0] nextWordIdx;
  logic             fetchOk;
  logic             frameSending;
  logic             colHit;

  assign padLen       = (lenQ < LEN_W'(MIN_BYTES)) ? LEN_W'(MIN_BYTES) : lenQ;
  assign payNibs      = {padLen, 1'b0};
  assign nextWordIdx  = (cnt >> 3) + CNT_W'(1);
  assign fetchOk      = {nextWordIdx, 2'b00} < (CNT_W + 2)'(lenQ);
  assign frameSending = (state == ST_PRE) || (state == ST_DATA) || (state == ST_FCS);
  assign colHit       = hdQ && col && frameSending;

  // buffer read requests, one cycle ahead of the word capture
  always_comb begin
    memRdEn   = 1'b0;
    memRdAddr = '0;
    if (state == ST_PRE && cnt == CNT_W'(14) && lenQ != '0) begin
      memRdEn = 1'b1;
    end else if (state == ST_DATA && cnt[2:0] == 3'd6 && fetchOk) begin
      memRdEn   = 1'b1;
      memRdAddr = nextWordIdx[ADDR_W-1:0];
    end
  end

  always_comb begin
    stb          = '0;
    stb.sel      = SEL_IDLE;
    stb.lane     = cnt[2:1];
    stb.hiNib    = cnt[0];
    stb.padZero  = (cnt >> 1) >= CNT_W'(lenQ);
    stb.loadWord = rdPend;
    stb.crcInit  = (state == ST_IDLE);
    case (state)
      ST_PRE:  stb.sel = (cnt == CNT_W'(15)) ? SEL_SFD : SEL_PRE;
      ST_DATA: begin stb.sel = SEL_DATA; stb.crcStep = 1'b1; end
      ST_FCS:  begin stb.sel = SEL_FCS;  stb.crcShift = 1'b1; end
      ST_JAM:  stb.sel = SEL_JAM;
      default: stb.sel = SEL_IDLE;
    endcase
  end

  assign txEn     = frameSending || (state == ST_JAM);
  assign done     = (state == ST_END);
  assign busy     = (state != ST_IDLE);
  assign collided = colFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      lenQ    <= '0;
      hdQ     <= 1'b0;
      colFlag <= 1'b0;
      rdPend  <= 1'b0;
    end else begin
      rdPend <= memRdEn;
      if (colHit) begin
        state   <= ST_JAM;
        cnt     <= '0;
        colFlag <= 1'b1;
      end else begin
        case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (start) begin
              lenQ    <= frameLen;
              hdQ     <= halfDuplex;
              colFlag <= 1'b0;
              state   <= (halfDuplex && crs) ? ST_DEFER : ST_PRE;
            end
          end
          ST_DEFER: if (!crs) state <= ST_PRE;
          ST_PRE: begin
            if (cnt == CNT_W'(15)) begin state <= ST_DATA; cnt <= '0; end
            else cnt <= cnt + CNT_W'(1);
          end
          ST_DATA: begin
            if (cnt == payNibs - CNT_W'(1)) begin state <= ST_FCS; cnt <= '0; end
            else cnt <= cnt + CNT_W'(1);
          end
          ST_FCS, ST_JAM: begin
            if (cnt == CNT_W'(7)) begin state <= ST_END; cnt <= '0; end
            else cnt <= cnt + CNT_W'(1);
          end
          default: begin state <= ST_IDLE; cnt <= '0; end
        endcase
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_END_AFTER_TX: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEn) |-> done); // R7
  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> ((LEN_W'(memRdAddr) << 2) < lenQ)); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(lenQ)); // R8
  AST_DEFER_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEFER && crs) |=> !txEn); // R9
  AST_COL_TO_JAM: assert property (@(posedge clk) disable iff (!rstN)
    colHit |=> (colFlag && txEn)); // R10
  AST_FULL_NO_COL: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !hdQ) |=> !colFlag); // R10

endmodule

// File: rtl/txf_dp.sv
module txf_dp
  import mii_txf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  txStrobe_t   stb,
  input  logic [31:0] memRdData,
  output logic [3:0]  txData
);

  logic [31:0] wordQ;
  logic [31:0] crcQ;
  logic [7:0]  laneByte;
  logic [3:0]  dataNib;
  logic [3:0]  nib;

  assign laneByte = wordQ[{stb.lane, 3'b000} +: 8];
  assign dataNib  = stb.padZero ? 4'h0 : (stb.hiNib ? laneByte[7:4] : laneByte[3:0]);

  always_comb begin
    case (stb.sel)
      SEL_PRE:  nib = PRE_NIB;
      SEL_SFD:  nib = SFD_NIB;
      SEL_DATA: nib = dataNib;
      SEL_FCS:  nib = ~crcQ[3:0];
      SEL_JAM:  nib = JAM_NIB;
      default:  nib = 4'h0;
    endcase
  end

  assign txData = nib;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
      crcQ  <= '1;
    end else begin
      if (stb.loadWord) wordQ <= memRdData;
      if (stb.crcInit)       crcQ <= '1;
      else if (stb.crcStep)  crcQ <= crcNibble(crcQ, nib);
      else if (stb.crcShift) crcQ <= {4'h0, crcQ[31:4]};
    end
  end

  AST_FCS_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sel == SEL_FCS) |-> ($past(stb.sel) == SEL_DATA || $past(stb.sel) == SEL_FCS)); // R6

endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
  import mii_txf_pkg::*;
#(
  parameter int MEM_DEPTH = 512,
  parameter int MIN_BYTES = 60,
  localparam int ADDR_W   = $clog2(MEM_DEPTH),
  localparam int LEN_W    = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              halfDuplex,
  input  logic              crs,
  input  logic              col,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              memRdEn,
  input  logic [31:0]       memRdData,
  output logic [3:0]        txData,
  output logic              txEn,
  output logic              txEr,
  output logic              done,
  output logic              collided,
  output logic              busy
);

  txStrobe_t stb;

  txf_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MIN_BYTES(MIN_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .frameLen(frameLen),
    .halfDuplex(halfDuplex), .crs(crs), .col(col),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .stb(stb),
    .txEn(txEn), .done(done), .collided(collided), .busy(busy)
  );

  txf_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .memRdData(memRdData), .txData(txData)
  );

  assign txEr = 1'b0;

endmodule

// File: tb/sim_mii_tx_framer.sv
module sim_mii_tx_framer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [11:0] frameLen = '0;
  logic        halfDuplex = 1'b0;
  logic        crs = 1'b0;
  logic        col = 1'b0;
  logic [8:0]  memRdAddr;
  logic        memRdEn;
  logic [31:0] memRdData = '0;
  logic [3:0]  txData;
  logic        txEn, txEr, done, collided, busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] mem [512];
  int rdQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mii_tx_framer u0 (
    .clk(clk), .rstN(rstN), .start(start), .frameLen(frameLen),
    .halfDuplex(halfDuplex), .crs(crs), .col(col),
    .memRdAddr(memRdAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .txData(txData), .txEn(txEn), .txEr(txEr), .done(done),
    .collided(collided), .busy(busy)
  );

  // transmit buffer: one cycle read latency
  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= mem[memRdAddr];
      rdQ.push_back(int'(memRdAddr));
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byteVal(input int n, input int seed);
    return 8'((n * 37) + (seed * 11) + 3);
  endfunction

  function automatic logic [31:0] crcByte(input logic [31:0] cIn, input logic [7:0] b);
    logic [31:0] c;
    c = cIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic fillMem(input int seed);
    for (int w = 0; w < 512; w++)
      mem[w] = {byteVal(4*w+3, seed), byteVal(4*w+2, seed), byteVal(4*w+1, seed), byteVal(4*w, seed)};
  endtask

  // colAt / restartAt are frame nibble indices, -1 for none
  task automatic runFrame(input int len, input bit hd, input int deferCyc, input bit crsHold,
                          input int colAt, input int restartAt, input int seed);
    logic [3:0] expQ[$];
    string tagQ[$];
    logic [31:0] crc;
    logic [7:0] v;
    int padLen, nWords, totalCyc, f;
    bit colOn;
    colOn = hd && (colAt >= 0);
    fillMem(seed);
    crc = 32'hFFFF_FFFF;
    for (int i = 0; i < 15; i++) begin expQ.push_back(4'h5); tagQ.push_back("R2"); end
    expQ.push_back(4'hD); tagQ.push_back("R2");
    padLen = (len < 60) ? 60 : len;
    for (int b = 0; b < padLen; b++) begin
      v = (b < len) ? byteVal(b, seed) : 8'h00;
      crc = crcByte(crc, v);
      expQ.push_back(v[3:0]); tagQ.push_back((b < len) ? "R3" : "R5");
      expQ.push_back(v[7:4]); tagQ.push_back((b < len) ? "R3" : "R5");
    end
    crc = ~crc;
    for (int i = 0; i < 8; i++) begin expQ.push_back(crc[4*i +: 4]); tagQ.push_back("R6"); end
    if (colOn) begin
      while (expQ.size() > colAt + 1) begin void'(expQ.pop_back()); void'(tagQ.pop_back()); end
      for (int i = 0; i < 8; i++) begin expQ.push_back(4'hA); tagQ.push_back("R10"); end
    end
    rdQ.delete();
    @(negedge clk);
    frameLen = 12'(len);
    halfDuplex = hd;
    crs = (deferCyc > 0) || crsHold;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    totalCyc = deferCyc + expQ.size();
    for (int k = 0; k < totalCyc; k++) begin
      start = 1'b0;
      col = 1'b0;
      if (k < deferCyc) begin
        chk(txEn == 1'b0 && busy == 1'b1, "R9", "txEn during deferral", int'(txEn), 0);
        if (k == deferCyc - 1) crs = crsHold;
      end else begin
        f = k - deferCyc;
        chk(txEn == 1'b1 && txData == expQ[f], tagQ[f], $sformatf("nibble %0d {en,data}", f),
            int'({txEn, txData}), int'({1'b1, expQ[f]}));
        if (f == colAt) col = 1'b1;
        if (f == restartAt) begin start = 1'b1; frameLen = 12'd7; end
      end
      @(negedge clk);
    end
    start = 1'b0;
    col = 1'b0;
    chk(done == 1'b1 && txEn == 1'b0, "R7", "end cycle {done,txEn}", int'({done, txEn}), 2);
    chk(collided == colOn, "R10", "collided flag", int'(collided), int'(colOn));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0 && txEn == 1'b0, "R7", "after end {done,busy,txEn}",
        int'({done, busy, txEn}), 0);
    if (!colOn) begin
      nWords = (len + 3) / 4;
      chk(rdQ.size() == nWords, "R4", "word reads", rdQ.size(), nWords);
      for (int i = 0; i < rdQ.size() && i < nWords; i++)
        chk(rdQ[i] == i, "R4", $sformatf("read %0d address", i), rdQ[i], i);
    end
    crs = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && txEn == 1'b0, "R8", "idle after frame", int'({busy, txEn}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txEn == 1'b0 && done == 1'b0 && busy == 1'b0 && collided == 1'b0 && txData == 4'h0,
        "R1", "reset outputs", int'({txEn, done, busy, collided, txData}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(txEr == 1'b0, "R11", "txEr idle", int'(txEr), 0);

    runFrame(64, 1'b0, 0, 1'b0, -1, -1, 1);    // R2 R3 R4 R6 R7 full words
    runFrame(10, 1'b0, 0, 1'b0, -1, -1, 2);    // R5 short frame
    runFrame(0, 1'b0, 0, 1'b0, -1, -1, 3);     // R5 empty frame, no reads
    runFrame(60, 1'b0, 0, 1'b0, -1, -1, 4);    // R5 boundary, no pad
    runFrame(61, 1'b0, 0, 1'b0, -1, -1, 5);    // R3 R4 partial last word
    runFrame(100, 1'b0, 0, 1'b1, 40, -1, 6);   // R9 R10 full duplex ignores crs/col
    runFrame(64, 1'b1, 5, 1'b0, -1, -1, 7);    // R9 deferral
    runFrame(64, 1'b1, 0, 1'b0, 30, -1, 8);    // R10 collision in payload
    runFrame(64, 1'b1, 0, 1'b0, 3, -1, 9);     // R10 collision in preamble
    runFrame(64, 1'b0, 0, 1'b0, -1, 20, 10);   // R8 start while busy
    chk(txEr == 1'b0, "R11", "txEr after frames", int'(txEr), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule